// File: doc/BRIEF.md
# Fetch Address Sequencer

This block holds the address of the instruction being fetched and decides, once per clock, where fetching continues. It serves a 32-bit instruction stream whose words sit on 4-byte boundaries. The fetch address register has no load enable and takes a new value on every rising edge.

Three sources compete for the next address:

- **Fall-through:** the current address plus four.
- **Relative branch:** a target computed from the fall-through address and a signed displacement carried in the instruction.
- **Region jump:** a target that keeps the upper bits of the fall-through address and fills the rest from an index field in the instruction.

The decode logic drives a branch request and a jump request. The execute stage drives the equality flag. The block also presents the fall-through address as an output so that link or compare logic can reuse it.

A thin top connects a small select unit to the address datapath. The select unit passes its decision to the datapath as a packed struct of two strobes.

Top module: `pc_sequencer`

## Requirements
- R1: When `rst` is high at a rising edge, `fetchAddr` becomes 0x00000000 after that edge, whatever the other inputs are.
- R2: `seqAddr` always equals `fetchAddr` + 4, modulo 2^32.
- R3: With `jmpReq` low and `brReq` and `aluZero` not both high, `fetchAddr` after the edge equals `seqAddr` before it.
- R4: With `jmpReq` low and both `brReq` and `aluZero` high, the next `fetchAddr` is `seqAddr` + 4 × (instruction bits 15:0 read as a signed two's-complement number).
- R5: A branch request with `aluZero` low, or `aluZero` high without a branch request, has no effect: the next address is the fall-through one.
- R6: With `jmpReq` high, the next `fetchAddr` is bits 31:28 of `seqAddr`, followed by instruction bits 25:0, followed by two zero bits. This holds whatever `brReq` and `aluZero` are.
- R7: Bits 1:0 of `fetchAddr` are 0 in every cycle after reset.
- R8: All address arithmetic wraps modulo 2^32. The fall-through from 0xFFFFFFFC is 0x00000000, and a backward branch from 0x00000000 can reach 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instrWord | input | 32 | Current instruction; bits 25:0 are the jump index and bits 15:0 are the branch displacement |
| brReq | input | 1 | Conditional branch request from decode |
| aluZero | input | 1 | Equality flag from the ALU |
| jmpReq | input | 1 | Unconditional jump request from decode |
| fetchAddr | output | 32 | Current fetch address (register output) |
| seqAddr | output | 32 | Fall-through address, `fetchAddr` + 4 |

## Verification
The bound checker tests the following on every clock:

- the fall-through relation;
- word alignment;
- the register's response to reset;
- that each of the three selection outcomes (fall-through, branch, jump) loads the address it should.

Some properties show only through the bench's directed and random scenarios, which compare against a behavioural model:

- wrap-around at the top and bottom of the address space;
- a jump whose region bits change because the fall-through address crosses a 256 MiB boundary;
- negative displacements;
- a reset applied in mid-run.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  // Strobes passed from the select unit to the address datapath.
  typedef struct packed {
    logic takeJump;
    logic takeBranch;
  } pcSelT;
endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic  brReq,
  input  logic  aluZero,
  input  logic  jmpReq,
  output pcSelT sel
);
  // A jump overrides any branch; a branch needs both request and equality.
  always_comb begin
    sel.takeJump   = jmpReq;
    sel.takeBranch = brReq && aluZero && !jmpReq;
  end
endmodule

// File: rtl/pc_seq_dp.sv
module pc_seq_dp
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 26,
  parameter int DISP_W  = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  pcSelT             sel,
  input  logic [IDX_W-1:0]  jmpIdx,
  input  logic [DISP_W-1:0] brDisp,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] incAddr
);
  localparam int REGION_W = ADDR_W - IDX_W - 2;
  localparam int EXT_W    = ADDR_W - DISP_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] dispScaled;
  logic [ADDR_W-1:0] brTarget;
  logic [ADDR_W-1:0] jmpTarget;
  logic [ADDR_W-1:0] nextAddr;

  assign incAddr    = pcQ + STEP;
  assign dispScaled = {{EXT_W{brDisp[DISP_W-1]}}, brDisp, 2'b00};
  assign brTarget   = incAddr + dispScaled;
  assign jmpTarget  = {incAddr[ADDR_W-1 -: REGION_W], jmpIdx, 2'b00};

  always_comb begin
    nextAddr = incAddr;
    if (sel.takeJump)        nextAddr = jmpTarget;
    else if (sel.takeBranch) nextAddr = brTarget;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= RESET_ADDR;
    else     pcQ <= nextAddr;
  end

  assign curAddr = pcQ;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 26,
  parameter int DISP_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               brReq,
  input  logic               aluZero,
  input  logic               jmpReq,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic [ADDR_W-1:0]  seqAddr
);
  pcSelT sel;
  logic  unusedOpcode;

  assign unusedOpcode = ^instrWord[INSTR_W-1:IDX_W];

  pc_seq_ctrl u_ctrl (
    .brReq   (brReq),
    .aluZero (aluZero),
    .jmpReq  (jmpReq),
    .sel     (sel)
  );

  pc_seq_dp #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DISP_W (DISP_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .jmpIdx  (instrWord[IDX_W-1:0]),
    .brDisp  (instrWord[DISP_W-1:0]),
    .curAddr (fetchAddr),
    .incAddr (seqAddr)
  );
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 26,
  parameter int DISP_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instrWord,
  input logic               brReq,
  input logic               aluZero,
  input logic               jmpReq,
  input logic [ADDR_W-1:0]  fetchAddr,
  input logic [ADDR_W-1:0]  seqAddr
);
  localparam int REGION_W = ADDR_W - IDX_W - 2;

  // R1: reset loads zero
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> fetchAddr == '0);

  // R2: fall-through output tracks the register
  p_seq_plus4_r2: assert property (@(posedge clk) disable iff (rst)
    seqAddr == fetchAddr + ADDR_W'(4));

  // R3, R5: no jump and no taken branch means fall-through
  p_fallthrough_r3: assert property (@(posedge clk) disable iff (rst)
    (!jmpReq && !(brReq && aluZero)) |=> fetchAddr == $past(seqAddr));

  // R4: taken branch
  p_branch_r4: assert property (@(posedge clk) disable iff (rst)
    (!jmpReq && brReq && aluZero) |=>
      fetchAddr == $past(seqAddr) +
        ADDR_W'($signed($past(instrWord[DISP_W-1:0]))) * ADDR_W'(4));

  // R6: jump wins
  p_jump_r6: assert property (@(posedge clk) disable iff (rst)
    jmpReq |=> fetchAddr == {$past(seqAddr[ADDR_W-1 -: REGION_W]),
                             $past(instrWord[IDX_W-1:0]), 2'b00});

  // R7: alignment
  p_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    fetchAddr[1:0] == 2'b00);
endmodule

bind pc_sequencer pc_sequencer_chk #(
  .ADDR_W (ADDR_W), .INSTR_W (INSTR_W), .IDX_W (IDX_W), .DISP_W (DISP_W)
) u_chk (.*);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrWord = '0;
  logic        brReq = 1'b0;
  logic        aluZero = 1'b0;
  logic        jmpReq = 1'b0;
  logic [31:0] fetchAddr;
  logic [31:0] seqAddr;

  int checks = 0;
  int errors = 0;
  logic [31:0] refPc = '0;
  logic [31:0] pcLog[$];

  always #4 clk = ~clk;  // 125 MHz

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rst(rst), .instrWord(instrWord), .brReq(brReq),
    .aluZero(aluZero), .jmpReq(jmpReq), .fetchAddr(fetchAddr), .seqAddr(seqAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural model of one clock: arithmetic on integers, not the RTL's muxing.
  function automatic logic [31:0] model(input logic [31:0] pc, input logic [31:0] iw,
                                        input logic b, input logic z, input logic j);
    longint base = longint'(pc) + 4;
    longint off  = longint'($signed(iw[15:0])) * 4;
    if (j)      return 32'((base & 64'hF000_0000) | (longint'(iw[25:0]) << 2));
    if (b && z) return 32'(base + off);
    return 32'(base);
  endfunction

  // Drive at a falling edge, step one clock, compare after the edge.
  task automatic step(input string req, input logic [31:0] iw,
                      input logic b, input logic z, input logic j);
    @(negedge clk);
    instrWord = iw; brReq = b; aluZero = z; jmpReq = j;
    refPc = rst ? 32'h0 : model(refPc, iw, b, z, j);
    @(posedge clk);
    #1;
    pcLog.push_back(fetchAddr);
    check(req, fetchAddr, refPc);
    check("R2", seqAddr, refPc + 32'd4);
    check("R7", {30'd0, fetchAddr[1:0]}, 32'd0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step("R1", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);       // reset dominates
    rst = 1'b0;
    step("R3", 32'h0, 1'b0, 1'b0, 1'b0);               // 4
    step("R3", 32'h0, 1'b0, 1'b0, 1'b0);               // 8
    step("R5", 32'h0000_0010, 1'b1, 1'b0, 1'b0);       // branch, no zero: 12
    step("R5", 32'h0000_0010, 1'b0, 1'b1, 1'b0);       // zero, no branch: 16
    step("R4", 32'h0000_0010, 1'b1, 1'b1, 1'b0);       // 20+64 = 84
    check("R4", fetchAddr, 32'd84);
    step("R4", 32'h0000_FFFB, 1'b1, 1'b1, 1'b0);       // 88-20 = 68
    check("R4", fetchAddr, 32'd68);
    step("R6", 32'h0000_0040, 1'b1, 1'b1, 1'b1);       // jump beats branch: 0x100
    check("R6", fetchAddr, 32'h0000_0100);
    // wrap: reset then backward branch from 0
    rst = 1'b1; step("R1", 32'h0, 1'b0, 1'b0, 1'b0); rst = 1'b0;
    check("R1", fetchAddr, 32'h0);
    step("R8", 32'h0000_FFFE, 1'b1, 1'b1, 1'b0);       // 4-8 -> FFFFFFFC
    check("R8", fetchAddr, 32'hFFFF_FFFC);
    step("R8", 32'h0, 1'b0, 1'b0, 1'b0);               // wraps to 0
    check("R8", fetchAddr, 32'h0);
    // region crossing jump
    step("R6", 32'h03FF_FFFF, 1'b0, 1'b0, 1'b1);       // 0x0FFFFFFC
    check("R6", fetchAddr, 32'h0FFF_FFFC);
    step("R6", 32'h0000_0003, 1'b0, 1'b0, 1'b1);       // seq 0x10000000 -> 0x1000000C
    check("R6", fetchAddr, 32'h1000_000C);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] iw = $urandom;
      logic [2:0]  c  = 3'($urandom);
      step(c[2] ? "R6" : ((c[1] && c[0]) ? "R4" : "R3"), iw, c[1], c[0], c[2]);
    end
    rst = 1'b1; step("R1", 32'h1234_5678, 1'b0, 1'b1, 1'b0); rst = 1'b0;
    check("R1", fetchAddr, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule